// File: doc/BRIEF.md
# Serial EEPROM Slave Engine

This block is the digital core of a serial EEPROM that answers on a four-wire SPI bus in mode 0. The system clock oversamples the select, serial clock and serial data input; each frame opens with an 8-bit op-code, MSB first. Read and write op-codes take a three-byte address, and only the low `ADDR_W` bits of it are used. Reads stream bytes out from a running address until select rises. Writes fill a page buffer. The buffer is committed to the array only as a full page, and only when select rises on a byte boundary.

A commit starts an internal programming cycle that lasts `BUSY_CLKS` system clocks. During that cycle only the status read is answered. A write-enable latch must be set before any array or status change, and it clears again after every completed change. Two block-protect bits fence off part of the array. A protect-enable bit combined with the active-low WP pin locks the status register.

Top module: `spi_eeprom_slave`

## Requirements
- R1: A frame is an op-code (0x06 set latch, 0x05 read status, 0x03 read, 0x02 page write, 0x01 status write). For read and write it is followed by a 24-bit address, MSB first. Address bits at or above `ADDR_W` are ignored.
- R2: After a read address, SO carries the addressed bytes MSB first. SO changes on SCK falling edges. The address increments per byte and wraps from the top address to 0.
- R3: During a page write only the low 7 address bits advance per byte, and the page number stays fixed. Bytes beyond 128 overwrite the earlier bytes at the same offsets.
- R4: The array changes only when select rises on a byte boundary after at least 128 data bytes. A shorter page, or a rise in the middle of a byte, leaves the array and the busy bit unchanged.
- R5: A page write op-code received while the write-enable latch is clear has no effect on the array.
- R6: While a programming cycle runs, status bit 0 reads 1. Every op-code other than read status is ignored, including the latch-set op-code.
- R7: The write-enable latch (status bit 1) clears when a programming cycle ends and when a status write is committed.
- R8: A status write takes one data byte and commits at select rise on a byte boundary. It is committed only if the latch is set and not (bit 7 set and WP low). It loads bit 7 and bits 3:2.
- R9: While WP is held low, status bit 7 cannot go from 1 to 0.
- R10: Status bits 3:2 select the protected region: 00 none, 01 the upper quarter, 10 the upper half, 11 the whole array. A page write into a protected page is dropped, and busy is not set.
- R11: After reset the status byte is 0x00, laid out as {bit7, 0, 0, 0, protect[1:0], latch, busy}. so_oe is high only while select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| so | output | 1 | Serial data out, valid while so_oe is high |
| so_oe | output | 1 | Output enable for so |

## Verification
The bound checker watches the internal state on every cycle. It confirms that the latch never rises while busy and is clear whenever busy falls. It also confirms that a programming cycle only starts with the latch set, that the array is written only during busy, that no write lands in a protected address, and that bit 7 holds while WP is low. Only the bench scenarios can show the serial framing. That covers address truncation, read wrap-around, the 7-bit page wrap with overwrite, partial and mid-byte aborts, and lockout of op-codes during busy, each compared against an expected memory image built in the bench.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] OP_SETWEL = 8'h06;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PGWR   = 8'h02;
  localparam logic [7:0] OP_WRSTAT = 8'h01;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRIN, ST_STAT, ST_IGNORE
  } cmd_st_t;
endpackage

// File: rtl/spi_rx_front.sv
module spi_rx_front
  import eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              sel,
  output logic              sck_fall,
  output logic              cs_rise,
  output logic              aligned,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_s, sck_q, cs_s, cs_q, si_s;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              sck_rise;

  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_s;
  assign cs_rise  = cs_s & ~cs_q;
  assign sel      = ~cs_s;
  assign aligned  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= 1'b0; sck_q <= 1'b0; si_s <= 1'b0;
      cs_s <= 1'b1; cs_q <= 1'b1;
      sh <= '0; cnt <= '0; byte_done <= 1'b0; rx_byte <= '0;
    end else begin
      sck_s <= sck; sck_q <= sck_s; si_s <= si;
      cs_s <= cs_n; cs_q <= cs_s;
      byte_done <= 1'b0;
      if (cs_s) begin
        cnt <= '0;
      end else if (sck_rise) begin
        sh  <= {sh[BYTE_W-2:0], si_s};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(BYTE_W-1)) begin
          byte_done <= 1'b1;
          rx_byte   <= {sh[BYTE_W-2:0], si_s};
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
  parameter int ADDR_W = 10
) (
  input  logic [1:0]        bp,
  input  logic              wpen,
  input  logic              wp_n,
  input  logic              wel,
  input  logic [ADDR_W-1:0] addr,
  output logic              blk_prot,
  output logic              sr_ok
);
  always_comb begin
    unique case (bp)
      2'b00: blk_prot = 1'b0;
      2'b01: blk_prot = &addr[ADDR_W-1:ADDR_W-2];
      2'b10: blk_prot = addr[ADDR_W-1];
      default: blk_prot = 1'b1;
    endcase
  end

  assign sr_ok = wel & ~(wpen & ~wp_n);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 7,
  parameter int BUSY_CLKS = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int CW   = $clog2(BUSY_CLKS + 1);
  localparam int PN_W = ADDR_W - PAGE_W;

  logic              sel, sck_fall, cs_rise, aligned, byte_done;
  logic [BYTE_W-1:0] rx_byte, mem_q, so_sr, sr_new, status;
  cmd_st_t           state;
  logic              wel, busy, wpen, is_rd, sr_got;
  logic [1:0]        bp, acnt;
  logic [ADDR_W-1:0] addr_r, rd_addr;
  logic [PN_W-1:0]   page_no;
  logic [PAGE_W-1:0] widx;
  logic [PAGE_W:0]   nbytes;
  logic [CW-1:0]     prog_cnt;
  logic              mem_we, blk_prot, sr_ok;
  logic [ADDR_W-1:0] mem_waddr;
  logic [BYTE_W-1:0] pbuf [PAGE];

  spi_rx_front u_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .sel(sel), .sck_fall(sck_fall), .cs_rise(cs_rise), .aligned(aligned),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  eeprom_guard #(.ADDR_W(ADDR_W)) u_guard (
    .bp(bp), .wpen(wpen), .wp_n(wp_n), .wel(wel),
    .addr({page_no, {PAGE_W{1'b0}}}), .blk_prot(blk_prot), .sr_ok(sr_ok)
  );

  assign mem_we    = busy && (prog_cnt < CW'(PAGE));
  assign mem_waddr = {page_no, prog_cnt[PAGE_W-1:0]};

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr),
    .wdata(pbuf[prog_cnt[PAGE_W-1:0]]), .raddr(rd_addr), .rdata(mem_q)
  );

  assign status = {wpen, 3'b000, bp, wel, busy};
  assign so     = so_sr[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (byte_done && state == ST_WDATA) pbuf[widx] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OP; wel <= 1'b0; busy <= 1'b0; wpen <= 1'b0; bp <= '0;
      is_rd <= 1'b0; sr_got <= 1'b0; sr_new <= '0; acnt <= '0;
      addr_r <= '0; rd_addr <= '0; page_no <= '0; widx <= '0;
      nbytes <= '0; prog_cnt <= '0; so_sr <= '0; so_oe <= 1'b0;
    end else begin
      so_oe <= sel;
      if (busy) begin
        prog_cnt <= prog_cnt + 1'b1;
        if (prog_cnt == CW'(BUSY_CLKS - 1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end
      end
      if (byte_done) begin
        unique case (state)
          ST_OP: begin
            acnt <= '0;
            if (busy) state <= (rx_byte == OP_RDSTAT) ? ST_STAT : ST_IGNORE;
            else begin
              unique case (rx_byte)
                OP_SETWEL: begin wel <= 1'b1; state <= ST_IGNORE; end
                OP_RDSTAT: state <= ST_STAT;
                OP_READ:   begin is_rd <= 1'b1; state <= ST_ADDR; end
                OP_PGWR:   begin is_rd <= 1'b0; state <= wel ? ST_ADDR : ST_IGNORE; end
                OP_WRSTAT: state <= wel ? ST_SRIN : ST_IGNORE;
                default:   state <= ST_IGNORE;
              endcase
            end
          end
          ST_ADDR: begin
            addr_r <= ADDR_W'({addr_r, rx_byte});
            acnt   <= acnt + 1'b1;
            if (acnt == 2'd2) begin
              if (is_rd) begin
                rd_addr <= ADDR_W'({addr_r, rx_byte});
                state   <= ST_RDATA;
              end else begin
                page_no <= PN_W'({addr_r, rx_byte} >> PAGE_W);
                widx    <= PAGE_W'(rx_byte);
                nbytes  <= '0;
                state   <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            widx <= widx + 1'b1;
            if (nbytes != (PAGE_W+1)'(PAGE)) nbytes <= nbytes + 1'b1;
          end
          ST_SRIN: begin
            sr_new <= rx_byte;
            sr_got <= 1'b1;
            state  <= ST_IGNORE;
          end
          default: ;
        endcase
      end
      if (sck_fall && (state == ST_RDATA || state == ST_STAT)) begin
        if (aligned) begin
          so_sr <= (state == ST_STAT) ? status : mem_q;
          if (state == ST_RDATA) rd_addr <= rd_addr + 1'b1;
        end else begin
          so_sr <= {so_sr[BYTE_W-2:0], 1'b0};
        end
      end
      if (cs_rise) begin
        state  <= ST_OP;
        sr_got <= 1'b0;
        if (state == ST_WDATA && aligned && nbytes == (PAGE_W+1)'(PAGE)
            && wel && !busy && !blk_prot) begin
          busy     <= 1'b1;
          prog_cnt <= '0;
        end
        if (sr_got && aligned && sr_ok && !busy) begin
          wpen <= sr_new[7];
          bp   <= sr_new[3:2];
          wel  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_chk.sv
module eeprom_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wp_n,
  input logic              wpen,
  input logic              wel,
  input logic              busy,
  input logic [1:0]        bp,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr
);
  logic in_fence;
  always_comb begin
    case (bp)
      2'b00:   in_fence = 1'b0;
      2'b01:   in_fence = (mem_waddr[ADDR_W-1:ADDR_W-2] == 2'b11);
      2'b10:   in_fence = mem_waddr[ADDR_W-1];
      default: in_fence = 1'b1;
    endcase
  end

  // R9
  wpen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && $past(!wp_n) && $past(wpen)) |-> wpen);
  // R6
  wel_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> !$past(busy));
  // R7
  wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);
  // R5
  start_wel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));
  // R4
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  // R10
  write_fence_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !in_fence);
endmodule

bind spi_eeprom_slave eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wp_n(wp_n), .wpen(wpen), .wel(wel), .busy(busy),
  .bp(bp), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 9;
  localparam int SIZE = 1 << AW;
  localparam int HALF = 3;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_mem [SIZE];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(7), .BUSY_CLKS(400)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe)
  );

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] dat(input logic [7:0] s, input int k);
    return s ^ 8'(k * 37 + k / 128);
  endfunction

  task automatic model_write(input logic [23:0] a, input int n, input logic [7:0] s);
    for (int k = 0; k < n; k++)
      exp_mem[{a[AW-1:7], 7'(a[6:0] + 7'(k))}] = dat(s, k);
  endtask

  task automatic fstart();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic fend();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = so;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic one_op(input logic [7:0] op);
    logic [7:0] r;
    fstart(); xfer(op, r); fend();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] r;
    fstart(); xfer(8'h05, r); xfer(8'h00, v); fend();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    fstart(); xfer(8'h01, r); xfer(v, r); fend();
  endtask

  task automatic pwrite(input logic [23:0] a, input int n, input logic [7:0] s, input int tail);
    logic [7:0] r;
    fstart();
    xfer(8'h02, r); xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(dat(s, k), r);
    for (int i = 0; i < tail; i++) begin
      si = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    fend();
  endtask

  task automatic pread(input logic [23:0] a, input int n, input string tag);
    logic [7:0] r;
    fstart();
    xfer(8'h03, r); xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    check({tag, " so_oe low select"}, int'(so_oe), 1);
    for (int k = 0; k < n; k++) begin
      xfer(8'hA5, r);
      check(tag, int'(r), int'(exp_mem[AW'(int'(a[AW-1:0]) + k)]));
    end
    fend();
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 40; i++) begin
      rdsr(v);
      if (!v[0]) break;
    end
  endtask

  task automatic stat_is(input string tag, input int expv);
    logic [7:0] v;
    rdsr(v);
    check(tag, int'(v), expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 so_oe idle", int'(so_oe), 0);
    stat_is("R11 reset status", 8'h00);
    check("R11 so_oe after frame", int'(so_oe), 0);

    // R3 R6 R7: fill each page, busy/latch observed, latch clears
    for (int p = 0; p < 4; p++) begin
      one_op(8'h06);
      pwrite(24'(p * 128), 128, 8'(p * 17 + 1), 0);
      model_write(24'(p * 128), 128, 8'(p * 17 + 1));
      stat_is("R6 busy after commit", 8'h03);
      wait_idle();
      stat_is("R7 latch cleared", 8'h00);
    end

    // R1: upper address bits ignored, wrap across top
    pread(24'hFE01FE, 4, "R1 truncated address");

    // R5: write with latch clear
    pwrite(24'h000080, 128, 8'h5C, 0);
    stat_is("R5 no busy", 8'h00);
    pread(24'h000080, 8, "R5 page unchanged");

    // R3: 130 bytes from offset 0x7E of page 2
    one_op(8'h06);
    pwrite(24'h00017E, 130, 8'h3B, 0);
    model_write(24'h00017E, 130, 8'h3B);
    wait_idle();
    pread(24'h000100, 128, "R3 page wrap");

    // R4: short page and mid-byte rise
    one_op(8'h06);
    pwrite(24'h000000, 10, 8'h77, 0);
    stat_is("R4 short page dropped", 8'h02);
    pwrite(24'h000000, 128, 8'h77, 3);
    stat_is("R4 mid-byte dropped", 8'h02);
    pread(24'h000000, 4, "R4 array unchanged");

    // R6: lockout during busy
    pwrite(24'h000180, 128, 8'hC4, 0);
    model_write(24'h000180, 128, 8'hC4);
    one_op(8'h06);
    wrsr(8'h0C);
    stat_is("R6 busy lockout", 8'h03);
    wait_idle();
    stat_is("R6 latch op ignored while busy", 8'h00);

    // R10 R8: protection levels
    one_op(8'h06); wrsr(8'h04);
    stat_is("R8 status write quarter", 8'h04);
    one_op(8'h06);
    pwrite(24'h000180, 128, 8'h11, 0);
    stat_is("R10 quarter fence drop", 8'h06);
    pwrite(24'h000100, 128, 8'h22, 0);
    model_write(24'h000100, 128, 8'h22);
    stat_is("R10 unfenced page busy", 8'h07);
    wait_idle();
    one_op(8'h06); wrsr(8'h08);
    stat_is("R8 status write half", 8'h08);
    one_op(8'h06);
    pwrite(24'h000100, 128, 8'h33, 0);
    stat_is("R10 half fence drop", 8'h0A);
    wrsr(8'h0C);
    stat_is("R8 status write all", 8'h0C);
    one_op(8'h06);
    pwrite(24'h000000, 128, 8'h44, 0);
    stat_is("R10 full fence drop", 8'h0E);

    // R9 R8: protect-enable with WP pin
    wrsr(8'h80);
    stat_is("R8 set protect-enable", 8'h80);
    wp_n = 1'b0;
    one_op(8'h06); wrsr(8'h00);
    stat_is("R9 bit7 held with WP low", 8'h82);
    pwrite(24'h000080, 128, 8'h66, 0);
    model_write(24'h000080, 128, 8'h66);
    stat_is("R8 array writable with WP low", 8'h83);
    wait_idle();
    stat_is("R7 latch cleared after cycle", 8'h80);
    wp_n = 1'b1;
    one_op(8'h06); wrsr(8'h00);
    stat_is("R8 clear with WP high", 8'h00);
    wrsr(8'h04);
    stat_is("R8 no latch no change", 8'h00);

    // R2: full continuous read with wrap
    pread(24'h000000, SIZE + 2, "R2 continuous read");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule